// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block is a real-time clock core. It keeps the time of day and the calendar date in packed BCD counters: seconds, minutes, hours, day of month, month, two-digit year and a weekday. The counters advance on a one-cycle pulse from a 1 Hz tick input. A run/halt state machine lets software freeze the counters while it loads a new time. A snapshot command copies the live counters into a set of read shadows, so that one coherent time can be read byte by byte.

A six-byte alarm set is compared against the advancing counters. A status byte holds four periodic event flags, an alarm flag and a power-up flag. All flags are cleared by writing one to them. An interrupt-enable byte selects the periodic event that can raise the interrupt and gates the alarm. The single interrupt output stays high for as long as an enabled flag remains set. The host uses a byte-wide synchronous port. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational from `addr`.

The run/halt state machine has two states. In `ST_HALT` the counters ignore ticks. In `ST_RUN` every tick advances them. A control write with bit 0 set takes the `START` transition from `ST_HALT` to `ST_RUN`. A control write with bit 0 clear takes the `STOP` transition back. Every other cycle holds the state. Reset enters `ST_HALT`.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the live counters and the shadows hold seconds 00, minutes 00, hours 00, day 01, month 01, year 00 and weekday 00. The alarm bytes, the control byte and the interrupt byte read 00. The status byte reads 0x80 (power-up flag only), and irq is low.
- R2: A counting tick adds one in BCD to the seconds. Seconds go from 59 to 00 and carry into minutes. Minutes go from 59 to 00 and carry into hours. Hours go from 23 to 00 and carry into the date.
- R3: Control byte (address 0x0D) bit 0 starts the clock when written 1 and halts it when written 0. This bit reads back at bit 0 and is mirrored in status bit 1. While the clock is halted, ticks change nothing.
- R4: On a day carry, the day wraps from the month's length to 01 and carries into the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00. The weekday (address 0x06) steps from 00 to 06 and then wraps, once per day carry.
- R5: Writing addresses 0x00 to 0x06 (seconds, minutes, hours, day, month, year, weekday) loads that live counter at once, whether the clock runs or not. If a tick arrives in the same cycle, the written value replaces that field's counted value.
- R6: Reads of 0x00 to 0x06 return the shadows. A control write with bit 6 set copies the live counters, as they stood before that edge, into the shadows. Nothing else changes the shadows, and control bit 6 reads 0.
- R7: The alarm bytes at 0x07 to 0x0C (seconds through year) read back as written. Status bit 6 is set by a counting tick whose result equals all six alarm bytes.
- R8: Each counting tick sets status bit 2. A seconds wrap also sets bit 3, a minutes wrap also sets bit 4, and an hours wrap also sets bit 5.
- R9: Writing the status byte (address 0x0E) with a 1 in any of bits 2 to 7 clears that flag, and a 0 leaves it alone. A flag set by a tick in the same cycle stays set. Bit 7 is set only by reset.
- R10: In the interrupt byte (address 0x0F), bits 1:0 pick the periodic flag (0 second, 1 minute, 2 hour, 3 day), bit 2 enables the periodic interrupt and bit 3 enables the alarm interrupt. irq is high exactly when (alarm flag and bit 3) or (picked flag and bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check the following: a seconds write lands in the live counter, a halted clock keeps its counters, seconds 59 wraps to 00, the shadows move only on a snapshot command, and clearing both enables drops irq. The calendar lengths, the leap-year rule, the year wrap, the alarm match and the same-cycle clash between a status clear and a new flag appear only in the bench's scenarios. There, a behavioural model tracks every register and the interrupt on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int N_FIELDS = 7;
    localparam int N_ALARM  = 6;
    localparam int N_EV     = 4;

    typedef logic [ADDR_W-1:0] rtc_addr_t;
    typedef logic [BYTE_W-1:0] rtc_byte_t;
    typedef logic [N_FIELDS-1:0][BYTE_W-1:0] rtc_time_t;
    typedef logic [N_ALARM-1:0][BYTE_W-1:0]  rtc_alarm_t;

    // field index equals its register address
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;
    localparam int F_WDAY = 6;

    localparam rtc_addr_t A_ALM0 = 4'h7;
    localparam rtc_addr_t A_CTRL = 4'hD;
    localparam rtc_addr_t A_STAT = 4'hE;
    localparam rtc_addr_t A_INTR = 4'hF;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_SNAP = 6;
    localparam int ST_RUN    = 1;
    localparam int ST_EV0    = 2;
    localparam int ST_ALM    = 6;
    localparam int ST_PWR    = 7;
    localparam int IE_TMR    = 2;
    localparam int IE_ALM    = 3;

    function automatic rtc_byte_t bcd_inc(input rtc_byte_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_bin(input rtc_byte_t v);
        return (7'(v[7:4]) * 7'd10) + 7'(v[3:0]);
    endfunction

    function automatic rtc_byte_t month_len(input rtc_byte_t mon, input rtc_byte_t year);
        logic [6:0] yb;
        logic       leap;
        yb   = bcd_bin(year);
        leap = (yb[1:0] == 2'b00);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t reset_time();
        rtc_time_t t;
        t         = '0;
        t[F_DAY]  = 8'h01;
        t[F_MON]  = 8'h01;
        return t;
    endfunction

endpackage

// File: rtl/rtc_runctl.sv
module rtc_runctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic run_bit,
    output logic running
);

    typedef enum logic {ST_HALT, ST_RUN} run_state_e;

    run_state_e state_q, state_d;

    // next state: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && run_bit)  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !run_bit) state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN);
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              time_wr,
    input  rtc_addr_t         wr_idx,
    input  rtc_byte_t         wr_data,
    output rtc_time_t         cur,
    output rtc_alarm_t        nxt_cmp,
    output logic [N_EV-1:0]   ev
);

    localparam rtc_time_t RST_T = reset_time();

    rtc_time_t adv;
    rtc_byte_t dim;
    logic      c_s, c_m, c_h, c_d, c_mo;

    // carry chain from seconds up to year
    always_comb begin
        c_s  = (cur[F_SEC] == 8'h59);
        c_m  = c_s && (cur[F_MIN] == 8'h59);
        c_h  = c_m && (cur[F_HOUR] == 8'h23);
        dim  = month_len(cur[F_MON], cur[F_YEAR]);
        c_d  = c_h && (cur[F_DAY] >= dim);
        c_mo = c_d && (cur[F_MON] >= 8'h12);

        adv        = cur;
        adv[F_SEC] = c_s ? 8'h00 : bcd_inc(cur[F_SEC]);
        if (c_s) adv[F_MIN]  = c_m ? 8'h00 : bcd_inc(cur[F_MIN]);
        if (c_m) adv[F_HOUR] = c_h ? 8'h00 : bcd_inc(cur[F_HOUR]);
        if (c_h) begin
            adv[F_DAY]  = c_d ? 8'h01 : bcd_inc(cur[F_DAY]);
            adv[F_WDAY] = (cur[F_WDAY] >= 8'h06) ? 8'h00 : bcd_inc(cur[F_WDAY]);
        end
        if (c_d)  adv[F_MON]  = c_mo ? 8'h01 : bcd_inc(cur[F_MON]);
        if (c_mo) adv[F_YEAR] = (cur[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur[F_YEAR]);

        nxt_cmp = adv[N_ALARM-1:0];
        ev      = count_en ? {c_h, c_m, c_s, 1'b1} : '0;
    end

    // one counter per field; a write beats the tick
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   cur[g] <= RST_T[g];
            else if (time_wr && wr_idx == rtc_addr_t'(g)) cur[g] <= wr_data;
            else if (count_en)                            cur[g] <= adv[g];
        end
    end

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  rtc_addr_t       addr,
    input  rtc_byte_t       wdata,
    input  logic            running,
    input  logic            count_en,
    input  rtc_time_t       cur,
    input  rtc_alarm_t      nxt_cmp,
    input  logic [N_EV-1:0] ev,
    output rtc_byte_t       rdata,
    output rtc_time_t       snap,
    output logic            irq
);

    localparam rtc_time_t RST_T = reset_time();

    rtc_alarm_t      alm_q;
    logic [N_EV-1:0] ev_q;
    logic            alm_flag, pu_q;
    logic [3:0]      ie_q;
    logic            snap_req, stat_wr, alarm_hit;

    always_comb begin
        snap_req  = wr_en && (addr == A_CTRL) && wdata[CTRL_SNAP];
        stat_wr   = wr_en && (addr == A_STAT);
        alarm_hit = count_en && (nxt_cmp == alm_q);
    end

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_snap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        snap[g] <= RST_T[g];
            else if (snap_req) snap[g] <= cur[g];
        end
    end

    for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) alm_q[g] <= '0;
            else if (wr_en && addr == rtc_addr_t'(int'(A_ALM0) + g)) alm_q[g] <= wdata;
        end
    end

    // write-one-to-clear flags; a new event wins over the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q     <= '0;
            alm_flag <= 1'b0;
            pu_q     <= 1'b1;
            ie_q     <= '0;
        end else begin
            ev_q     <= (ev_q & ~({N_EV{stat_wr}} & wdata[ST_EV0 +: N_EV])) | ev;
            alm_flag <= (alm_flag & ~(stat_wr & wdata[ST_ALM])) | alarm_hit;
            pu_q     <= pu_q & ~(stat_wr & wdata[ST_PWR]);
            if (wr_en && addr == A_INTR) ie_q <= wdata[3:0];
        end
    end

    always_comb begin
        irq = (alm_flag & ie_q[IE_ALM]) | (ev_q[ie_q[1:0]] & ie_q[IE_TMR]);
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_FIELDS; i++)
            if (addr == rtc_addr_t'(i)) rdata = snap[i];
        for (int i = 0; i < N_ALARM; i++)
            if (addr == rtc_addr_t'(int'(A_ALM0) + i)) rdata = alm_q[i];
        if (addr == A_CTRL) rdata[CTRL_RUN] = running;
        if (addr == A_STAT) rdata = {pu_q, alm_flag, ev_q, running, 1'b0};
        if (addr == A_INTR) rdata = {4'b0, ie_q};
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq
);

    logic            running, count_en, time_wr, ctrl_wr;
    rtc_time_t       cur_time, snap_time;
    rtc_alarm_t      nxt_cmp;
    logic [N_EV-1:0] ev;

    always_comb begin
        count_en = tick && running;
        time_wr  = wr_en && (addr < A_ALM0);
        ctrl_wr  = wr_en && (addr == A_CTRL);
    end

    rtc_runctl u_runctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .run_bit (wdata[CTRL_RUN]),
        .running (running)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .time_wr  (time_wr),
        .wr_idx   (addr),
        .wr_data  (wdata),
        .cur      (cur_time),
        .nxt_cmp  (nxt_cmp),
        .ev       (ev)
    );

    rtc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .running  (running),
        .count_en (count_en),
        .cur      (cur_time),
        .nxt_cmp  (nxt_cmp),
        .ev       (ev),
        .rdata    (rdata),
        .snap     (snap_time),
        .irq      (irq)
    );

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick,
    input logic      wr_en,
    input rtc_addr_t addr,
    input rtc_byte_t wdata,
    input logic      irq,
    input logic      running,
    input rtc_time_t cur_time,
    input rtc_time_t snap_time
);

    a_r5_write_loads_sec: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h0) |=> (cur_time[F_SEC] == $past(wdata)));

    a_r3_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(cur_time));

    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && !wr_en && cur_time[F_SEC] == 8'h59) |=> (cur_time[F_SEC] == 8'h00));

    a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_CTRL && wdata[CTRL_SNAP]) |=> $stable(snap_time));

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_INTR && wdata[3:2] == 2'b00) |=> !irq);

endmodule

bind bcd_rtc_core rtc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq       (irq),
    .running   (running),
    .cur_time  (cur_time),
    .snap_time (snap_time)
);

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
    import rtc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc_core dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // behavioural reference model (binary integers)
    int         m_t[7], m_snap[7], m_alm[6];
    bit         m_run, m_alarm, m_pu;
    bit         m_ev[4];
    logic [3:0] m_ie;

    function automatic int b2i(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(int v);
        logic [7:0] r;
        r[7:4] = 4'(v / 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    function automatic int mdays(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_t    = '{0, 0, 0, 1, 1, 0, 0};
        m_snap = '{0, 0, 0, 1, 1, 0, 0};
        m_alm  = '{default: 0};
        m_ev   = '{default: 0};
        m_run = 0; m_alarm = 0; m_pu = 1; m_ie = '0;
    endtask

    always @(posedge clk) begin
        int  old[7];
        int  nt[7];
        bit  evs[4];
        bit  hit;
        if (!rst_n) model_reset();
        else begin
            old = m_t; nt = m_t; evs = '{default: 0}; hit = 0;
            if (tick && m_run) begin
                evs[0] = 1; nt[0]++;
                if (nt[0] == 60) begin
                    nt[0] = 0; evs[1] = 1; nt[1]++;
                    if (nt[1] == 60) begin
                        nt[1] = 0; evs[2] = 1; nt[2]++;
                        if (nt[2] == 24) begin
                            nt[2] = 0; evs[3] = 1; nt[6] = (nt[6] + 1) % 7; nt[3]++;
                            if (nt[3] > mdays(old[4], old[5])) begin
                                nt[3] = 1; nt[4]++;
                                if (nt[4] > 12) begin
                                    nt[4] = 1; nt[5] = (nt[5] + 1) % 100;
                                end
                            end
                        end
                    end
                end
                hit = 1;
                for (int i = 0; i < 6; i++) if (nt[i] != m_alm[i]) hit = 0;
            end
            for (int i = 0; i < 4; i++) begin
                if (wr_en && addr == 4'hE && wdata[i+2]) m_ev[i] = 0;
                if (evs[i]) m_ev[i] = 1;
            end
            if (wr_en && addr == 4'hE && wdata[6]) m_alarm = 0;
            if (hit) m_alarm = 1;
            if (wr_en && addr == 4'hE && wdata[7]) m_pu = 0;
            if (wr_en) begin
                if (addr < 4'h7)       nt[addr] = b2i(wdata);
                else if (addr <= 4'hC) m_alm[addr-7] = b2i(wdata);
                else if (addr == 4'hD) begin
                    m_run = wdata[0];
                    if (wdata[6]) m_snap = old;
                end
                else if (addr == 4'hF) m_ie = wdata[3:0];
            end
            m_t = nt;
        end
    end

    function automatic logic [7:0] mread(logic [3:0] a);
        if (a < 4'h7)  return i2b(m_snap[a]);
        if (a <= 4'hC) return i2b(m_alm[a-7]);
        if (a == 4'hD) return {7'b0, m_run};
        if (a == 4'hE) return {m_pu, m_alarm, m_ev[3], m_ev[2], m_ev[1], m_ev[0], m_run, 1'b0};
        return {4'b0, m_ie};
    endfunction

    function automatic logic m_irq();
        return (m_alarm && m_ie[3]) || (m_ev[m_ie[1:0]] && m_ie[2]);
    endfunction

    function automatic string tag_of(logic [3:0] a);
        if (a < 4'h7)  return "R6 shadow read";
        if (a <= 4'hC) return "R7 alarm read";
        if (a == 4'hD) return "R3 control read";
        if (a == 4'hE) return "R9 status read";
        return "R10 interrupt read";
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: compare against the model, then drive the next inputs
    task automatic step(logic we, logic [3:0] a, logic [7:0] d, logic tk);
        @(negedge clk);
        if (rst_n) begin
            chk(tag_of(addr), rdata, mread(addr));
            chk("R10 irq vs model", {7'b0, irq}, {7'b0, m_irq()});
        end
        wr_en = we; addr = a; wdata = d; tick = tk;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d); step(1, a, d, 0); endtask
    task automatic tk();                             step(0, 0, 0, 1); endtask

    task automatic expect_reg(logic [3:0] a, logic [7:0] mask, logic [7:0] exp, string tag);
        step(0, a, 0, 0);
        #1;
        chk(tag, rdata & mask, exp);
    endtask

    task automatic expect_irq(logic exp, string tag);
        step(0, 0, 0, 0);
        #1;
        chk(tag, {7'b0, irq}, {7'b0, exp});
    endtask

    task automatic expect_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                               logic [7:0] d, logic [7:0] mo, logic [7:0] y, string tag);
        wr(4'hD, {1'b0, 1'b1, 5'b0, m_run});
        expect_reg(4'h0, 8'hFF, s,  tag);
        expect_reg(4'h1, 8'hFF, mi, tag);
        expect_reg(4'h2, 8'hFF, h,  tag);
        expect_reg(4'h3, 8'hFF, d,  tag);
        expect_reg(4'h4, 8'hFF, mo, tag);
        expect_reg(4'h5, 8'hFF, y,  tag);
    endtask

    task automatic load(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                        logic [7:0] d, logic [7:0] mo, logic [7:0] y);
        wr(4'h0, s); wr(4'h1, mi); wr(4'h2, h);
        wr(4'h3, d); wr(4'h4, mo); wr(4'h5, y);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int i = 0; i < 7; i++)
            expect_reg(4'(i), 8'hFF, (i == 3 || i == 4) ? 8'h01 : 8'h00, "R1 reset time");
        for (int i = 7; i < 14; i++) expect_reg(4'(i), 8'hFF, 8'h00, "R1 reset alarm/control");
        expect_reg(4'hE, 8'hFF, 8'h80, "R1 reset status");
        expect_reg(4'hF, 8'hFF, 8'h00, "R1 reset interrupt byte");
        expect_irq(0, "R1 reset irq");

        // R9 zero write keeps flag, one write clears it
        wr(4'hE, 8'h00);
        expect_reg(4'hE, 8'hFF, 8'h80, "R9 zero write no effect");
        wr(4'hE, 8'h80);
        expect_reg(4'hE, 8'hFF, 8'h00, "R9 power-up cleared");

        // R3 halted clock ignores ticks
        tk(); tk();
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R3 halted ticks ignored");

        // R2 R4 day/month rollover in a non-leap February
        load(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03);
        wr(4'h6, 8'h06);
        wr(4'hD, 8'h01);
        expect_reg(4'hE, 8'h02, 8'h02, "R3 running status");
        expect_reg(4'hD, 8'hFF, 8'h01, "R3 control readback");
        tk(); tk();
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h03, "R2 R4 rollover to March");
        expect_reg(4'h6, 8'hFF, 8'h00, "R4 weekday wrap");
        expect_reg(4'hE, 8'hFF, 8'h3E, "R8 all event flags");

        // R4 leap February and year wrap
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
        tk();
        expect_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, "R4 leap day");
        load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
        tk();
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R4 year wrap");

        // R7 alarm match
        wr(4'h7, 8'h05); wr(4'h8, 8'h00); wr(4'h9, 8'h00);
        wr(4'hA, 8'h01); wr(4'hB, 8'h01); wr(4'hC, 8'h00);
        expect_reg(4'h7, 8'hFF, 8'h05, "R7 alarm readback");
        wr(4'hE, 8'hFC);
        wr(4'hF, 8'h08);
        tk(); tk(); tk(); tk();
        expect_irq(0, "R7 no alarm before match");
        tk();
        expect_irq(1, "R7 R10 alarm irq");
        expect_reg(4'hE, 8'h40, 8'h40, "R7 alarm flag");
        wr(4'hE, 8'h40);
        expect_irq(0, "R9 alarm cleared");

        // R10 periodic selection
        wr(4'hF, 8'h05);
        wr(4'hE, 8'hFC);
        tk();
        expect_irq(0, "R10 minute select, second event only");
        wr(4'h0, 8'h59);
        tk();
        expect_irq(1, "R10 minute event irq");
        expect_reg(4'hE, 8'h3C, 8'h0C, "R8 second and minute flags");
        wr(4'hF, 8'h04);
        expect_irq(1, "R10 second select");
        wr(4'hF, 8'h00);
        expect_irq(0, "R10 disabled");

        // R5 write wins over tick; R6 snapshot holds
        step(1, 4'h0, 8'h30, 1);
        wr(4'hD, 8'h41);
        expect_reg(4'h0, 8'hFF, 8'h30, "R5 write beats tick");
        tk(); tk(); tk();
        expect_reg(4'h0, 8'hFF, 8'h30, "R6 shadow unchanged");
        expect_reg(4'hD, 8'hFF, 8'h01, "R6 snapshot bit reads 0");
        wr(4'hD, 8'h41);
        expect_reg(4'h0, 8'hFF, 8'h33, "R2 counted seconds");

        // R9 new flag wins over same-cycle clear
        wr(4'hE, 8'hFC);
        step(1, 4'hE, 8'h04, 1);
        expect_reg(4'hE, 8'h04, 8'h04, "R9 set wins over clear");

        // R3 stop
        wr(4'hD, 8'h00);
        expect_reg(4'hE, 8'h02, 8'h00, "R3 halted status");
        tk(); tk();
        wr(4'hD, 8'h40);
        expect_reg(4'h0, 8'hFF, 8'h34, "R3 frozen after stop");

        step(0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule